// File: doc/BRIEF.md
# Floating-Point Register Narrow-Value Boxing Unit

This unit sits between a 64-bit floating-point register file and the execution units. It shapes values whose format is narrower than the register: half precision (16 bits) and single precision (32 bits). A narrow value kept in a register is valid only when it occupies the low bits and every bit above it is one. The unit builds that form when a value is written into a register. It strips it when a value is transferred out. It checks it when an operand is read for computation.

Each request carries a 64-bit value, a precision code and an operation code. Requests arrive on a valid/ready input stream. The shaped value and a substitution flag leave on a valid/ready output stream one cycle later, through a single register stage. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being emptied in the same cycle. An output item stays on the port, unchanged, until `out_ready` is seen high. Arithmetic, rounding and exception flags are handled elsewhere.

Top module: `nanbox_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. An accepted request appears on the output in the following cycle. While `out_valid` is 1 and `out_ready` is 0, `out_value` and `out_subst` hold still.
- R3: Operation code 0 (transfer into register) with a narrow precision gives the low n bits of the input with all 64-n upper bits set to one.
- R4: Operation code 3 (computed result write) with a narrow precision also gives the low n bits with all upper bits forced to one.
- R5: Operation code 1 (transfer out of register) with a narrow precision gives the low n bits with the upper bits cleared. The upper input bits are not examined, and `out_subst` is 0.
- R6: Operation code 2 (operand read for computation) with a narrow precision and all upper input bits one gives the low n bits, upper bits cleared, with `out_subst` 0.
- R7: Operation code 2 with a narrow precision and any upper input bit zero gives the canonical NaN of that width with upper bits cleared: 0x7E00 for half, 0x7FC00000 for single. `out_subst` is 1. `out_subst` is never 1 for any other operation code.
- R8: Precision code 2 (double) passes all 64 bits unchanged under every operation code, including NaN payloads, with `out_subst` 0. Precision code 3 is handled the same way as double.
- R9: Precision code 0 selects half (n=16) and code 1 selects single (n=32).
- R10: Items leave in the order they were accepted, and none is lost or duplicated under any pattern of back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_value | input | 64 | Register value or result to shape |
| in_prec | input | 2 | Precision code: 0 half, 1 single, 2 double, 3 treated as double |
| in_op | input | 2 | Operation code: 0 transfer in, 1 transfer out, 2 operand read, 3 result write |
| out_valid | output | 1 | Shaped item present |
| out_ready | input | 1 | Consumer takes the item this cycle |
| out_value | output | 64 | Shaped value |
| out_subst | output | 1 | Invalid box was replaced by a canonical NaN |

## Verification
The assertions assume two things. First, `in_value`, `in_prec` and `in_op` are known whenever `in_valid` is high. Second, `out_ready` is never X after reset. The stimulus drives every input at the falling edge from fixed-seed random values, and it always drives known values, including on idle cycles. Random operands have their upper bits forced to all ones about half the time, so that both valid and broken boxes are covered. The random `out_ready` pattern produces stalls of varying length while requests keep arriving.

// File: rtl/nbx_pkg.sv
package nbx_pkg;
  typedef enum logic [1:0] {
    PREC_HALF   = 2'd0,
    PREC_SINGLE = 2'd1,
    PREC_DOUBLE = 2'd2,
    PREC_RSVD   = 2'd3
  } nbx_prec_e;

  typedef enum logic [1:0] {
    OP_XFER_IN  = 2'd0,
    OP_XFER_OUT = 2'd1,
    OP_SRC_READ = 2'd2,
    OP_RES_WR   = 2'd3
  } nbx_op_e;

  localparam int NUM_NARROW = 2;

  function automatic int exp_bits(input int width);
    if (width <= 16)      return 5;
    else if (width <= 32) return 8;
    else                  return 11;
  endfunction
endpackage

// File: rtl/nbx_box_check.sv
module nbx_box_check #(
  parameter int FLEN = 64,
  parameter int W    = 32
) (
  input  logic [FLEN-1:0] value,
  output logic            box_ok,
  output logic [FLEN-1:0] low_bits,
  output logic [FLEN-1:0] boxed,
  output logic [FLEN-1:0] canon
);
  localparam int EXP_W = nbx_pkg::exp_bits(W);
  localparam int MAN_W = W - 1 - EXP_W;
  localparam int UP_W  = FLEN - W;

  localparam logic [W-1:0] CANON_N = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  assign box_ok   = &value[FLEN-1:W];
  assign low_bits = {{UP_W{1'b0}}, value[W-1:0]};
  assign boxed    = {{UP_W{1'b1}}, value[W-1:0]};
  assign canon    = {{UP_W{1'b0}}, CANON_N};
endmodule

// File: rtl/nbx_shaper.sv
module nbx_shaper #(
  parameter int FLEN     = 64,
  parameter int HALF_W   = 16,
  parameter int SINGLE_W = 32
) (
  input  logic [FLEN-1:0] value,
  input  logic [1:0]      prec,
  input  logic [1:0]      op,
  output logic [FLEN-1:0] shaped,
  output logic            subst
);
  import nbx_pkg::*;

  logic            ok_a    [NUM_NARROW];
  logic [FLEN-1:0] low_a   [NUM_NARROW];
  logic [FLEN-1:0] boxed_a [NUM_NARROW];
  logic [FLEN-1:0] canon_a [NUM_NARROW];

  for (genvar g = 0; g < NUM_NARROW; g++) begin : g_width
    localparam int WG = (g == 0) ? HALF_W : SINGLE_W;
    nbx_box_check #(.FLEN(FLEN), .W(WG)) u_chk (
      .value   (value),
      .box_ok  (ok_a[g]),
      .low_bits(low_a[g]),
      .boxed   (boxed_a[g]),
      .canon   (canon_a[g])
    );
  end

  logic narrow;
  logic sel;
  assign narrow = (prec == PREC_HALF) || (prec == PREC_SINGLE);
  assign sel    = (prec == PREC_SINGLE);

  always_comb begin
    shaped = value;
    subst  = 1'b0;
    if (narrow) begin
      unique case (op)
        OP_XFER_IN, OP_RES_WR: shaped = boxed_a[sel];
        OP_XFER_OUT:           shaped = low_a[sel];
        default: begin
          if (ok_a[sel]) begin
            shaped = low_a[sel];
          end else begin
            shaped = canon_a[sel];
            subst  = 1'b1;
          end
        end
      endcase
    end
  end

  // R7: replacement flag only comes from operand reads of narrow formats
  always_comb begin
    if (subst) begin
      p_subst_narrow_r7: assert (op == OP_SRC_READ && narrow);
    end
  end
endmodule

// File: rtl/nbx_pipe_reg.sv
module nbx_pipe_reg #(
  parameter int W = 65
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) out_data <= in_data;
  end

  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_accept_shows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/nanbox_unit.sv
module nanbox_unit #(
  parameter int FLEN     = 64,
  parameter int HALF_W   = 16,
  parameter int SINGLE_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [FLEN-1:0] in_value,
  input  logic [1:0]      in_prec,
  input  logic [1:0]      in_op,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [FLEN-1:0] out_value,
  output logic            out_subst
);
  import nbx_pkg::*;

  localparam int PW = FLEN + 1;

  logic [FLEN-1:0] shaped;
  logic            subst;
  logic [PW-1:0]   out_pack;

  nbx_shaper #(.FLEN(FLEN), .HALF_W(HALF_W), .SINGLE_W(SINGLE_W)) u_shape (
    .value (in_value),
    .prec  (in_prec),
    .op    (in_op),
    .shaped(shaped),
    .subst (subst)
  );

  nbx_pipe_reg #(.W(PW)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  ({subst, shaped}),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_pack)
  );

  assign out_subst = out_pack[FLEN];
  assign out_value = out_pack[FLEN-1:0];

  logic fire;
  assign fire = in_valid && in_ready;

  p_ready_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_box_in_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == OP_XFER_IN && in_prec == PREC_HALF)
      |=> (&out_value[FLEN-1:HALF_W]));

  p_result_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == OP_RES_WR && in_prec == PREC_SINGLE)
      |=> (&out_value[FLEN-1:SINGLE_W]) && !out_subst);

  p_out_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == OP_XFER_OUT && in_prec == PREC_SINGLE)
      |=> (out_value[FLEN-1:SINGLE_W] == '0) && !out_subst);

  p_subst_only_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op != OP_SRC_READ) |=> !out_subst);

  p_double_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_prec == PREC_DOUBLE) |=> (out_value == $past(in_value)) && !out_subst);
endmodule

// File: tb/nanbox_unit_bench.sv
module nanbox_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_value;
  logic [1:0]  in_prec;
  logic [1:0]  in_op;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_value;
  logic        out_subst;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  nanbox_unit u_nanbox_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_prec(in_prec), .in_op(in_op),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_value(out_value), .out_subst(out_subst)
  );

  function automatic logic [64:0] model(input logic [63:0] v, input logic [1:0] p,
                                        input logic [1:0] o);
    int n;
    logic [63:0] mask;
    logic [63:0] low;
    if (p == 2'd0) n = 16;
    else if (p == 2'd1) n = 32;
    else return {1'b0, v};
    mask = (64'd1 << n) - 64'd1;
    low  = v & mask;
    case (o)
      2'd0, 2'd3: return {1'b0, low | ~mask};
      2'd1:       return {1'b0, low};
      default: begin
        if ((v | mask) == 64'hFFFF_FFFF_FFFF_FFFF) return {1'b0, low};
        if (n == 16) return {1'b1, 64'h7E00};
        return {1'b1, 64'h7FC0_0000};
      end
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] p, input logic [1:0] o,
                                   input logic subst);
    if (p[1]) return "R8";
    case (o)
      2'd0: return "R3";
      2'd1: return "R5";
      2'd3: return "R4";
      default: return subst ? "R7" : "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [64:0] got, input logic [64:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  logic [64:0] exp_q[$];
  string       req_q[$];

  localparam int NDIR = 10;
  localparam int NRAND = 3000;

  task automatic make_item(input int i, output logic [63:0] v, output logic [1:0] p,
                           output logic [1:0] o);
    case (i)
      0: begin v = 64'hFFFF_FFFF_FFFF_3C00; p = 2'd0; o = 2'd2; end // R6 R9 half ok
      1: begin v = 64'hFFFF_FFFF_FFFE_3C00; p = 2'd0; o = 2'd2; end // R7 half broken
      2: begin v = 64'h7FFF_FFFF_3F80_0000; p = 2'd1; o = 2'd2; end // R7 single broken
      3: begin v = 64'h7FF4_0000_0000_1234; p = 2'd2; o = 2'd2; end // R8 NaN payload
      4: begin v = 64'h0000_0000_1234_5678; p = 2'd1; o = 2'd0; end // R3 R9
      5: begin v = 64'h0123_4567_89AB_CDEF; p = 2'd0; o = 2'd1; end // R5 no check
      6: begin v = 64'h0000_0000_0000_ABCD; p = 2'd0; o = 2'd3; end // R4
      7: begin v = 64'hDEAD_BEEF_0000_0001; p = 2'd3; o = 2'd0; end // R8 code 3
      8: begin v = 64'hFFFF_FFFF_7F80_0001; p = 2'd1; o = 2'd2; end // R6 single ok
      9: begin v = 64'h0000_0000_0000_0000; p = 2'd1; o = 2'd2; end // R7 zero upper
      default: begin
        v = {$urandom(), $urandom()};
        p = 2'($urandom_range(0, 3));
        o = 2'($urandom_range(0, 3));
        if ($urandom_range(0, 1) == 1) begin
          if (p == 2'd0) v[63:16] = '1;
          else if (p == 2'd1) v[63:32] = '1;
        end
      end
    endcase
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog got=hung exp=drained");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int seed_init;
    int idx;
    logic [63:0] v;
    logic [1:0]  p;
    logic [1:0]  o;
    logic        prev_stall;
    logic [64:0] prev_out;
    logic [64:0] e;
    seed_init = $urandom(32'd2024);
    rst_n = 1'b0; in_valid = 1'b0; in_value = '0; in_prec = '0; in_op = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {64'd0, out_valid}, 65'd0);
    check("R1", {64'd0, in_ready}, 65'd1);

    idx = 0;
    prev_stall = 1'b0;
    prev_out = '0;
    make_item(idx, v, p, o);
    while (idx < NDIR + NRAND || exp_q.size() != 0) begin
      @(negedge clk);
      if (prev_stall) check("R2", {out_subst, out_value}, prev_out);
      out_ready = (idx >= NDIR + NRAND) ? 1'b1 : ($urandom_range(0, 3) != 0);
      if (idx < NDIR + NRAND && $urandom_range(0, 4) != 0) begin
        in_valid = 1'b1; in_value = v; in_prec = p; in_op = o;
      end else begin
        in_valid = 1'b0; in_value = {$urandom(), $urandom()};
        in_prec = 2'($urandom()); in_op = 2'($urandom());
      end
      #1;
      check("R2", {64'd0, in_ready}, {64'd0, (!out_valid || out_ready)});
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R10 got=extra_item exp=none");
        end else begin
          check(req_q[0], {out_subst, out_value}, exp_q[0]);
          void'(exp_q.pop_front());
          void'(req_q.pop_front());
        end
      end
      if (in_valid && in_ready) begin
        e = model(v, p, o);
        exp_q.push_back(e);
        req_q.push_back(req_of(p, o, e[64]));
        idx++;
        if (idx < NDIR + NRAND) make_item(idx, v, p, o);
      end
      prev_stall = out_valid && !out_ready;
      prev_out = {out_subst, out_value};
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", {64'd0, out_valid}, 65'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) cycles <= cycles + 1;
endmodule